// File: doc/BRIEF.md
# Timer Capture/Compare Event Flags

This block holds the event-flag register of a four-channel timer group. Four flags record either capture edges on external channel pins or compare matches from the counter datapath. A fifth flag records counter wrap. Software reads the register over a small strobe-based bus and clears flags with a read-then-write handshake, so an event that lands between the read and the write is never lost.

Each flag has a companion arm bit. Every read of the register loads the arm bit with the flag value that was read, and the next write to the register consumes it. A written 0 clears a flag only when its arm bit is set. The timer mode input selects the source of flags A to D: synchronised pin edges in capture mode, and counter-match pulses in the compare and both PWM modes. Overflow pulses set the top flag in every mode. A combined interrupt request is the OR of each flag gated by its own enable.

Top module: `tmr_status_flags`

## Requirements
- R1: After reset all flags and arm bits are 0, so a read returns 0x70.
- R2: Read data places flags A, B, C and D on bits 0 to 3 and the overflow flag on bit 7. rdata_o is 0 whenever sel_i and rd_i are not both high.
- R3: Bits 4 to 6 always read as 1, and no write value changes them.
- R4: A flag clears in the cycle after a write of 0 to its bit position, provided the last read before that write saw the flag as 1.
- R5: A flag that hardware sets after a read that saw it as 0 survives a following write of 0.
- R6: Writing 1 to a flag bit never changes that flag.
- R7: Each write consumes all arm bits. A second write of 0 with no read in between clears nothing.
- R8: When a set event and a qualifying clear reach the same flag in the same cycle, the flag stays at 1.
- R9: In capture mode (mode_i = 00), flag x sets on the edge chosen by edge_sel_i[2x+1:2x]: 00 none, 01 rising, 10 falling, 11 both. The flag is visible three clock edges after the pin changes (two synchroniser stages, then edge detect).
- R10: In compare mode (01) and the PWM modes (10, 11), a pulse on match_i[x] sets flag x on the next edge and capture pins are ignored. In capture mode, match_i is ignored.
- R11: A pulse on ovf_i sets the overflow flag on the next edge in every mode.
- R12: irq_o is combinationally the OR of (flag AND enable) over the five flags, with irq_en_i bits 0 to 3 for A to D and bit 4 for overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when not reading |
| mode_i | input | 2 | Timer mode: 00 capture, 01 compare, 10 PWM, 11 PWM2 |
| cap_pin_i | input | 4 | Asynchronous capture pins A to D |
| edge_sel_i | input | 8 | Two-bit edge select per pin |
| match_i | input | 4 | Compare-match pulses A to D |
| ovf_i | input | 1 | Counter overflow pulse |
| irq_en_i | input | 5 | Per-flag interrupt enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench targets the handshake corners:
- A flag set between read and write. A design without arming would wipe it.
- A write of 1 after an arming read. A design clearing on any write would lose the flag.
- A second write of 0 with no new read. A design that never consumes the arm would clear here.
- A set colliding with a clear in one cycle. A clear-priority design would drop the event.

Every edge-select code is swept against both pin transitions on every pin, and irq_o timing pins the synchroniser depth to exactly three edges. The bench also checks that match pulses do nothing in capture mode and pin edges do nothing in compare mode. Finally, all 32 flag patterns are crossed with all 32 enable masks.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;
  localparam int unsigned N_CH    = 4;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned OVF_POS = 7;

  typedef enum logic [1:0] {
    MODE_CAPTURE = 2'b00,
    MODE_COMPARE = 2'b01,
    MODE_PWM     = 2'b10,
    MODE_PWM2    = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/tmr_cap_edge.sv
module tmr_cap_edge
  import tmr_flag_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] sel_i,
  output logic       edge_o
);
  // sh_q[SYNC_STAGES-1] is the synchronised level, sh_q[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] sh_q;
  logic rise, fall;
  edge_sel_e sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], pin_i};
  end

  assign sel  = edge_sel_e'(sel_i);
  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign fall = ~sh_q[SYNC_STAGES-1] & sh_q[SYNC_STAGES];

  always_comb begin
    unique case (sel)
      EDGE_RISE: edge_o = rise;
      EDGE_FALL: edge_o = fall;
      EDGE_BOTH: edge_o = rise | fall;
      default:   edge_o = 1'b0;
    endcase
  end

  // R9: a single-direction edge cannot pulse twice in a row
  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && $stable(sel_i) && sel_i != 2'b11) |=> !(edge_o && $stable(sel_i)));
endmodule

// File: rtl/tmr_event_sel.sv
module tmr_event_sel
  import tmr_flag_pkg::*;
#(
  parameter int unsigned CH = 4
) (
  input  logic [1:0]    mode_i,
  input  logic [CH-1:0] cap_evt_i,
  input  logic [CH-1:0] match_i,
  output logic [CH-1:0] set_o
);
  tmr_mode_e mode;
  assign mode = tmr_mode_e'(mode_i);

  for (genvar g = 0; g < CH; g++) begin : g_sel
    always_comb begin
      unique case (mode)
        MODE_CAPTURE: set_o[g] = cap_evt_i[g];
        default:      set_o[g] = match_i[g];
      endcase
    end
  end
endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, arm_q, clr;

  assign clr = wr_i & arm_q & ~wbit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= set_i | (flag_q & ~clr);  // set beats clear
      if (rd_i)      arm_q <= flag_q;
      else if (wr_i) arm_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  // R4: a flag only falls after an armed write of 0
  a_r4_clear_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(arm_q && wr_i && !wbit_i));
  // R8: a set event always leaves the flag at 1
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(set_i) |-> flag_q);
  // R7: a write without a read leaves the arm empty
  a_r7_arm_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i && !rd_i) |-> !arm_q);
endmodule

// File: rtl/tmr_status_flags.sv
module tmr_status_flags
  import tmr_flag_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  input  logic [1:0]          mode_i,
  input  logic [N_CH-1:0]     cap_pin_i,
  input  logic [2*N_CH-1:0]   edge_sel_i,
  input  logic [N_CH-1:0]     match_i,
  input  logic                ovf_i,
  input  logic [N_CH:0]       irq_en_i,
  output logic                irq_o
);
  localparam int unsigned N_FLAG   = N_CH + 1;
  localparam int unsigned SPARE_LO = N_CH;
  localparam int unsigned SPARE_HI = OVF_POS - 1;

  logic              rd_hit, wr_hit;
  logic [N_CH-1:0]   cap_evt, ch_set;
  logic [N_FLAG-1:0] set_vec, flags, wbits;
  logic [REG_W-1:0]  reg_view;

  assign rd_hit = sel_i & rd_i;
  assign wr_hit = sel_i & wr_i;

  for (genvar g = 0; g < N_CH; g++) begin : g_cap
    tmr_cap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (cap_pin_i[g]),
      .sel_i  (edge_sel_i[2*g+1:2*g]),
      .edge_o (cap_evt[g])
    );
  end

  tmr_event_sel #(.CH(N_CH)) u_evsel (
    .mode_i    (mode_i),
    .cap_evt_i (cap_evt),
    .match_i   (match_i),
    .set_o     (ch_set)
  );

  assign set_vec = {ovf_i, ch_set};
  assign wbits   = {wdata_i[OVF_POS], wdata_i[N_CH-1:0]};

  for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
    tmr_flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[g]),
      .rd_i   (rd_hit),
      .wr_i   (wr_hit),
      .wbit_i (wbits[g]),
      .flag_o (flags[g])
    );
  end

  always_comb begin
    reg_view                    = '1;
    reg_view[N_CH-1:0]          = flags[N_CH-1:0];
    reg_view[OVF_POS]           = flags[N_CH];
  end

  assign rdata_o = rd_hit ? reg_view : '0;
  assign irq_o   = |(flags & irq_en_i);

  // R11: the overflow flag only rises after an overflow pulse
  a_r11_ovf_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[N_CH]) |-> $past(ovf_i));
  // R3: spare bits read 1 even right after a write of 0s there
  a_r3_spare_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_hit && (wdata_i[SPARE_HI:SPARE_LO] != '1)) && rd_hit)
      |-> rdata_o[SPARE_HI:SPARE_LO] == '1);
  // R10: in capture mode, channel flags rise only from pin edges
  a_r10_capture_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flags[0]) && $past(mode_i) == 2'b00) |-> $past(cap_evt[0]));
endmodule

// File: tb/tmr_status_flags_tb.sv
module tmr_status_flags_tb;
  logic       clk = 0, rst_n = 0;
  logic       sel = 0, rd = 0, wr = 0, ovf = 0;
  logic [7:0] wdata = 0, edge_sel = 0;
  logic [7:0] rdata;
  logic [1:0] mode = 0;
  logic [3:0] pins = 0, match = 0;
  logic [4:0] irq_en = 0;
  logic       irq;
  int n_tests = 0, n_fail = 0;
  logic [7:0] d;

  always #10 clk = ~clk;

  tmr_status_flags u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .mode_i(mode), .cap_pin_i(pins),
    .edge_sel_i(edge_sel), .match_i(match), .ovf_i(ovf),
    .irq_en_i(irq_en), .irq_o(irq));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(output logic [7:0] v);
    @(negedge clk); sel = 1; rd = 1; #1 v = rdata;
    @(negedge clk); sel = 0; rd = 0;
  endtask

  task automatic wr_reg(input logic [7:0] v);
    @(negedge clk); sel = 1; wr = 1; wdata = v;
    @(negedge clk); sel = 0; wr = 0; wdata = 0;
  endtask

  task automatic pulse(input logic [3:0] m, input logic o);
    @(negedge clk); match = m; ovf = o;
    @(negedge clk); match = 0; ovf = 0;
  endtask

  task automatic clear_all();
    logic [7:0] t;
    rd_reg(t); wr_reg(8'h00);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_reg(d); chk(d, 8'h70, "R1 reset read");
    // R2 idle bus gives 0
    #1 chk(rdata, 8'h00, "R2 idle rdata");
    // R3 spare bits ignore writes
    wr_reg(8'h00); rd_reg(d); chk(d, 8'h70, "R3 after write 00");
    wr_reg(8'hFF); rd_reg(d); chk(d, 8'h70, "R3 after write FF");

    // R2 layout, R10 compare-family modes, R11 overflow
    for (int m = 1; m < 4; m++) begin
      mode = 2'(m);
      for (int k = 0; k < 4; k++) begin
        clear_all();
        pulse(4'(1 << k), 1'b0);
        rd_reg(d); chk(d, 8'h70 | 8'(1 << k), "R2 R10 match bit position");
      end
      clear_all(); pulse(4'h0, 1'b1);
      rd_reg(d); chk(d, 8'hF0, "R11 overflow bit7");
    end
    // R10 match ignored in capture mode, overflow still works (R11)
    mode = 2'b00; clear_all();
    pulse(4'hF, 1'b0); rd_reg(d); chk(d, 8'h70, "R10 match ignored in capture");
    pulse(4'h0, 1'b1); rd_reg(d); chk(d, 8'hF0, "R11 overflow in capture mode");

    // R5: set after read-as-0 survives write 0
    mode = 2'b01; clear_all();
    rd_reg(d); pulse(4'h1, 1'b0); wr_reg(8'h00);
    rd_reg(d); chk(d, 8'h71, "R5 late set survives");
    // R6: armed, write 1 keeps flag
    wr_reg(8'hFF); rd_reg(d); chk(d, 8'h71, "R6 write 1 no clear");
    // R7: arm consumed by that write, second write 0 clears nothing
    wr_reg(8'hFF); wr_reg(8'h00); rd_reg(d); chk(d, 8'h71, "R7 arm consumed");
    // R4: read-1 then write-0 clears; other armed flag written 1 kept
    pulse(4'h4, 1'b1);
    rd_reg(d); wr_reg(8'hFE); rd_reg(d); chk(d, 8'hF4, "R4 selective clear");
    rd_reg(d); wr_reg(8'h00); rd_reg(d); chk(d, 8'h70, "R4 clear all armed");
    // R8: set and clear in same cycle
    pulse(4'h2, 1'b0); rd_reg(d);
    @(negedge clk); sel = 1; wr = 1; wdata = 8'h00; match = 4'h2;
    @(negedge clk); sel = 0; wr = 0; match = 0;
    rd_reg(d); chk(d, 8'h72, "R8 set wins");

    // R9 capture sweep: pin x edge-select x transition
    mode = 2'b00;
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++)
        for (int dir = 0; dir < 2; dir++) begin
          logic hit;
          edge_sel = 0; pins = 0;
          if (dir == 1) pins[p] = 1'b1;
          repeat (4) @(negedge clk);
          edge_sel[2*p +: 2] = 2'(s);
          clear_all();
          pins[p] = ~pins[p];
          repeat (4) @(negedge clk);
          hit = (s == 3) || (s == 1 && dir == 0) || (s == 2 && dir == 1);
          rd_reg(d);
          chk(d, 8'h70 | (hit ? 8'(1 << p) : 8'h00), "R9 edge select sweep");
        end
    // R9 timing via irq: visible after exactly three edges
    edge_sel = 8'h01; pins = 0; irq_en = 5'h01;
    repeat (4) @(negedge clk); clear_all();
    pins[0] = 1'b1;
    repeat (2) @(negedge clk); #1 chk({7'd0, irq}, 8'd0, "R9 not before third edge");
    @(negedge clk); #1 chk({7'd0, irq}, 8'd1, "R9 at third edge");
    // R10 pins ignored in compare mode
    mode = 2'b01; edge_sel = 8'hFF; clear_all();
    pins = 4'h0; repeat (5) @(negedge clk);
    rd_reg(d); chk(d, 8'h70, "R10 pins ignored in compare");

    // R12 exhaustive flags x enables
    pins = 0; edge_sel = 0;
    for (int f = 0; f < 32; f++) begin
      clear_all();
      pulse(4'(f), f[4]);
      for (int e = 0; e < 32; e++) begin
        @(negedge clk); irq_en = 5'(e);
        #1 chk({7'd0, irq}, {7'd0, |(5'(f) & 5'(e))}, "R12 irq gating");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule